// File: doc/BRIEF.md
# Frame Statistics Counter Bank with Snapshot Freeze

This block keeps 64-bit frame statistics for one direction of an Ethernet MAC. The MAC's end-of-frame logic hands it one event per finished frame. The event carries the frame length in bytes, a CRC-error flag, a destination class, a control flag, pause and priority-pause flags, and a length-error flag. A separate one-cycle pulse marks each frame start. From these inputs the bank updates counters for length bins, destination class with and without CRC error, pause and priority-pause frames, short frames with a CRC error, frame starts, length errors and all CRC errors.

Software reads the counters through a 32-bit read port. A snapshot freezes the view that reads return, while the live counters keep counting underneath. The freeze starts when either the snapshot pin or a software freeze bit goes high. The pin is a plain level and is synchronous to the transmit clock. To make a transmit bank and a receive bank freeze in the same cycle, wire both banks' `snap_in` to one net.

The event input is a valid/ready stream. `ev_ready` is held high at all times, so the bank never applies back-pressure, and every cycle with `ev_valid` high counts as one frame. The register ports have no handshake. Write and read strobes are plain one-cycle pulses.

Top module: `frame_stat_bank`

## Requirements
- R1: After reset, every counter half, the status register (address 0x40) and the configuration register (address 0x41) all read as zero.
- R2: Counter k (0..27) is 64 bits wide. Its lower half is read at address 2k and its upper half at address 2k+1. Data is returned on `rd_data` with `rd_valid` high one cycle after `rd_en`.
- R3: Every valid frame increments exactly one length counter, or none. Counter 8 (oversize) is used when the length exceeds `max_frame_len`. Otherwise the bins are: counter 1 for exactly 64 bytes, 2 for 65–127, 3 for 128–255, 4 for 256–511, 5 for 512–1023, 6 for 1024–1518 and 7 for 1519 and above. Frames under 64 bytes land in no bin.
- R4: Counter 0 counts frames shorter than 64 bytes that carry a CRC error.
- R5: The class counters use `ev_cast` 0 = unicast, 1 = multicast, 2 = broadcast; value 3 counts in no class. A frame without a CRC error increments counter 9 + 2·cast + ctrl. A frame with a CRC error increments counter 15 + 2·cast + ctrl.
- R6: Pause frames count in counter 21 without a CRC error and 22 with one. Priority-pause frames count in 23 without and 24 with. Counter 27 counts every frame with a CRC error.
- R7: Counter 25 counts `sof_pulse` cycles and counter 26 counts frames with `ev_len_err` set.
- R8: The freeze level is `snap_in` OR configuration bit 1. At the first clock edge where that level is high, the bank captures the live values as they stood before that edge's increments. Status bit 1 reads 1 from the next cycle on. While it reads 1, counter reads return the captured values.
- R9: While frozen, the live counters keep counting. One cycle after the freeze level falls, status bit 1 reads 0 and reads return the live values, including every frame counted during the freeze.
- R10: Writing address 0x41 stores bit 1 as the software freeze bit. If bit 0 is 1, the write also zeroes every live counter and the captured copy at that edge. The clear beats any frame event in the same cycle. Counters wrap modulo 2^64.
- R11: `ev_ready` is always 1, and back-to-back valid frames are each counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (transmit clock domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Frame event valid |
| ev_ready | output | 1 | Always high; no back-pressure |
| ev_len | input | 16 | Frame length in bytes |
| ev_crc_err | input | 1 | Frame has a CRC error |
| ev_cast | input | 2 | Destination class: 0 unicast, 1 multicast, 2 broadcast, 3 none |
| ev_ctrl | input | 1 | Control frame |
| ev_pause | input | 1 | Pause frame |
| ev_pfc | input | 1 | Priority-pause frame |
| ev_len_err | input | 1 | Length/type field error |
| sof_pulse | input | 1 | One-cycle frame-start marker |
| max_frame_len | input | 16 | Largest non-oversize length |
| snap_in | input | 1 | Snapshot freeze level, shareable between banks |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Write address |
| wr_data | input | 2 | Bit 0 clear, bit 1 software freeze |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 7 | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |

## Verification
Two functions can fall on the same edge: a frame event together with a clear write, and a frame event together with the rising edge of the snapshot level. The bench provokes both by driving the event strobe and the write strobe, or the event strobe and `snap_in`, in the same cycle. Its reference model then predicts the result. The clear must leave every counter at zero with the frame lost. The capture must hold the pre-event values, while the live counter, once the freeze is released, shows the event. A clear issued during a freeze is also checked: it must zero the frozen view at once.

// File: rtl/fstat_pkg.sv
package fstat_pkg;
  localparam int LEN_W    = 16;
  localparam int NUM_CNT  = 28;
  localparam int NUM_BINS = 7;

  // counter indices (the read map depends on them)
  localparam int IX_SHORT_ERR = 0;
  localparam int IX_BIN0      = 1;
  localparam int IX_OVERSIZE  = 8;
  localparam int IX_CLASS_OK  = 9;
  localparam int IX_CLASS_ERR = 15;
  localparam int IX_PAUSE_OK  = 21;
  localparam int IX_PAUSE_ERR = 22;
  localparam int IX_PFC_OK    = 23;
  localparam int IX_PFC_ERR   = 24;
  localparam int IX_SOF       = 25;
  localparam int IX_LEN_ERR   = 26;
  localparam int IX_ANY_ERR   = 27;

  typedef enum logic [1:0] {
    CAST_UNI   = 2'd0,
    CAST_MULTI = 2'd1,
    CAST_BCAST = 2'd2,
    CAST_NONE  = 2'd3
  } cast_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             crc_err;
    cast_e            cast;
    logic             ctrl;
    logic             pause;
    logic             pfc;
    logic             len_err;
  } fstat_ev_t;

  // lower edge of each length bin
  function automatic int bin_lo(input int k);
    case (k)
      0: return 64;
      1: return 65;
      2: return 128;
      3: return 256;
      4: return 512;
      5: return 1024;
      default: return 1519;
    endcase
  endfunction
endpackage

// File: rtl/stat_classify.sv
module stat_classify
  import fstat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  input  fstat_ev_t          ev,
  input  logic               sof,
  input  logic [LEN_W-1:0]   max_len,
  output logic [NUM_CNT-1:0] hit
);
  logic over;
  assign over = ev.len > max_len;

  always_comb begin
    int idx;
    hit = '0;
    idx = 0;
    if (ev_valid) begin
      if (ev.crc_err && (ev.len < LEN_W'(64))) hit[IX_SHORT_ERR] = 1'b1;
      if (over) hit[IX_OVERSIZE] = 1'b1;
      for (int k = 0; k < NUM_BINS; k++) begin
        if (!over && (ev.len >= LEN_W'(bin_lo(k))) &&
            ((k == NUM_BINS-1) || (ev.len < LEN_W'(bin_lo(k+1)))))
          hit[IX_BIN0+k] = 1'b1;
      end
      if (ev.cast != CAST_NONE) begin
        idx = (ev.crc_err ? IX_CLASS_ERR : IX_CLASS_OK) + 2*int'(ev.cast) + int'(ev.ctrl);
        hit[idx] = 1'b1;
      end
      if (ev.pause) hit[ev.crc_err ? IX_PAUSE_ERR : IX_PAUSE_OK] = 1'b1;
      if (ev.pfc)   hit[ev.crc_err ? IX_PFC_ERR : IX_PFC_OK] = 1'b1;
      if (ev.len_err) hit[IX_LEN_ERR] = 1'b1;
      if (ev.crc_err) hit[IX_ANY_ERR] = 1'b1;
    end
    if (sof) hit[IX_SOF] = 1'b1;
  end

  // R3
  one_size_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit[IX_OVERSIZE:IX_BIN0]));

  // R5
  one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit[IX_PAUSE_OK-1:IX_CLASS_OK]));
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R10
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (cnt == $past(cnt) + W'(1)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/stat_shadow.sv
module stat_shadow #(
  parameter int N = 28,
  parameter int W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                freeze_in,
  input  logic [N-1:0][W-1:0] live,
  output logic [N-1:0][W-1:0] view,
  output logic                frozen
);
  logic [N-1:0][W-1:0] shadow;
  logic                capture;

  assign capture = freeze_in && !frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen <= 1'b0;
      shadow <= '0;
    end else begin
      frozen <= freeze_in;
      if (clr)          shadow <= '0;
      else if (capture) shadow <= live;
    end
  end

  assign view = frozen ? shadow : live;

  // R8
  capture_pre_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_in && !frozen && !clr) |=> (shadow == $past(live)));

  // R8
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !clr) |=> $stable(shadow));

  // R10
  shadow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (shadow == '0));
endmodule

// File: rtl/frame_stat_bank.sv
module frame_stat_bank
  import fstat_pkg::*;
#(
  parameter int RD_W        = 32,
  parameter int ADDR_W      = 7,
  parameter int STATUS_ADDR = 64,
  parameter int CFG_ADDR    = 65
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic              ev_crc_err,
  input  logic [1:0]        ev_cast,
  input  logic              ev_ctrl,
  input  logic              ev_pause,
  input  logic              ev_pfc,
  input  logic              ev_len_err,
  input  logic              sof_pulse,
  input  logic [LEN_W-1:0]  max_frame_len,
  input  logic              snap_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [RD_W-1:0]   rd_data
);
  localparam int CNT_W = 2 * RD_W;
  localparam int SPAN  = 2 * NUM_CNT;

  fstat_ev_t ev;
  assign ev = '{len: ev_len, crc_err: ev_crc_err, cast: cast_e'(ev_cast),
                ctrl: ev_ctrl, pause: ev_pause, pfc: ev_pfc, len_err: ev_len_err};
  assign ev_ready = 1'b1;

  logic cfg_wr, clr, soft_freeze;
  assign cfg_wr = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));
  assign clr    = cfg_wr && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      soft_freeze <= 1'b0;
    else if (cfg_wr) soft_freeze <= wr_data[1];
  end

  logic [NUM_CNT-1:0] hit;

  stat_classify u_classify (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (ev_valid),
    .ev       (ev),
    .sof      (sof_pulse),
    .max_len  (max_frame_len),
    .hit      (hit)
  );

  logic [NUM_CNT-1:0][CNT_W-1:0] live;
  logic [NUM_CNT-1:0][CNT_W-1:0] view;
  logic                          frozen;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    stat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (hit[g]),
      .cnt   (live[g])
    );
  end

  stat_shadow #(.N(NUM_CNT), .W(CNT_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .freeze_in (snap_in || soft_freeze),
    .live      (live),
    .view      (view),
    .frozen    (frozen)
  );

  logic [RD_W-1:0] rd_mux;
  always_comb begin
    int idx;
    logic [CNT_W-1:0] sel;
    idx    = int'(rd_addr >> 1);
    sel    = '0;
    rd_mux = '0;
    if (rd_addr < ADDR_W'(SPAN)) begin
      sel    = view[idx];
      rd_mux = rd_addr[0] ? sel[CNT_W-1:RD_W] : sel[RD_W-1:0];
    end else if (rd_addr == ADDR_W'(STATUS_ADDR)) begin
      rd_mux = RD_W'({frozen, 1'b0});
    end else if (rd_addr == ADDR_W'(CFG_ADDR)) begin
      rd_mux = RD_W'({soft_freeze, 1'b0});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R2
  no_spurious_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

// File: tb/frame_stat_bank_bench.sv
`timescale 1ns/1ps
module frame_stat_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 28;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic        ev_valid = 0, ev_crc_err = 0, ev_ctrl = 0, ev_pause = 0, ev_pfc = 0, ev_len_err = 0;
  logic [15:0] ev_len = 0, max_frame_len = 16'd1600;
  logic [1:0]  ev_cast = 0;
  logic        sof_pulse = 0, snap_in = 0, wr_en = 0, rd_en = 0;
  logic [6:0]  wr_addr = 0, rd_addr = 0;
  logic [1:0]  wr_data = 0;
  logic        ev_ready, rd_valid;
  logic [31:0] rd_data;

  frame_stat_bank u_frame_stat_bank (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_len(ev_len), .ev_crc_err(ev_crc_err), .ev_cast(ev_cast), .ev_ctrl(ev_ctrl),
    .ev_pause(ev_pause), .ev_pfc(ev_pfc), .ev_len_err(ev_len_err),
    .sof_pulse(sof_pulse), .max_frame_len(max_frame_len), .snap_in(snap_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // reference model
  logic [63:0] m_live [NC];
  logic [63:0] m_shad [NC];
  logic        m_fq = 0, m_cfg = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  string       cur_tag = "";

  function automatic logic [NC-1:0] ref_hits();
    logic [NC-1:0] h = '0;
    if (ev_valid) begin
      if (ev_crc_err && ev_len < 64) h[0] = 1;
      if (ev_len > max_frame_len) h[8] = 1;
      else if (ev_len == 64) h[1] = 1;
      else if (ev_len >= 65 && ev_len <= 127) h[2] = 1;
      else if (ev_len >= 128 && ev_len <= 255) h[3] = 1;
      else if (ev_len >= 256 && ev_len <= 511) h[4] = 1;
      else if (ev_len >= 512 && ev_len <= 1023) h[5] = 1;
      else if (ev_len >= 1024 && ev_len <= 1518) h[6] = 1;
      else if (ev_len >= 1519) h[7] = 1;
      if (ev_cast != 2'd3) h[(ev_crc_err ? 15 : 9) + 2*int'(ev_cast) + int'(ev_ctrl)] = 1;
      if (ev_pause) h[ev_crc_err ? 22 : 21] = 1;
      if (ev_pfc)   h[ev_crc_err ? 24 : 23] = 1;
      if (ev_len_err) h[26] = 1;
      if (ev_crc_err) h[27] = 1;
    end
    if (sof_pulse) h[25] = 1;
    return h;
  endfunction

  function automatic logic [31:0] ref_read(input logic [6:0] a);
    logic [63:0] v;
    if (a < 56) begin
      v = m_fq ? m_shad[a >> 1] : m_live[a >> 1];
      return a[0] ? v[63:32] : v[31:0];
    end
    if (a == 7'h40) return {30'd0, m_fq, 1'b0};
    if (a == 7'h41) return {30'd0, m_cfg, 1'b0};
    return 32'd0;
  endfunction

  initial for (int i = 0; i < NC; i++) begin m_live[i] = 0; m_shad[i] = 0; end

  always @(posedge clk) begin
    if (rst_n) begin
      logic [NC-1:0] h;
      logic          fr, clr, cw;
      h   = ref_hits();
      fr  = snap_in | m_cfg;
      cw  = wr_en && wr_addr == 7'h41;
      clr = cw && wr_data[0];
      if (rd_en) begin exp_q.push_back(ref_read(rd_addr)); tag_q.push_back(cur_tag); end
      for (int i = 0; i < NC; i++) begin
        if (clr) m_shad[i] = 0;
        else if (fr && !m_fq) m_shad[i] = m_live[i];
        if (clr) m_live[i] = 0;
        else if (h[i]) m_live[i] = m_live[i] + 64'd1;
      end
      m_fq = fr;
      if (cw) m_cfg = wr_data[1];
    end
  end

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid && !finished) begin
      if (exp_q.size() == 0) check_val("R2 unexpected rd_valid", 32'd1, 32'd0);
      else check_val(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic step();
    @(posedge clk); #1;
    ev_valid = 0; sof_pulse = 0; wr_en = 0; rd_en = 0;
    @(negedge clk);
  endtask

  task automatic set_frame(input int len, input bit crc, input int cast, input bit ctrl,
                           input bit pau, input bit pfc, input bit lerr);
    ev_len = 16'(len); ev_crc_err = crc; ev_cast = 2'(cast); ev_ctrl = ctrl;
    ev_pause = pau; ev_pfc = pfc; ev_len_err = lerr; ev_valid = 1;
  endtask

  task automatic frame(input int len, input bit crc, input int cast, input bit ctrl,
                       input bit pau, input bit pfc, input bit lerr);
    set_frame(len, crc, cast, ctrl, pau, pfc, lerr);
    step();
  endtask

  task automatic rd(input int a, input string tag);
    cur_tag = tag; rd_addr = 7'(a); rd_en = 1; step();
  endtask

  task automatic wr(input int a, input int d);
    wr_addr = 7'(a); wr_data = 2'(d); wr_en = 1; step();
  endtask

  function automatic string tag_of(input int k);
    if (k == 0) return "R4 short-crc";
    if (k <= 8) return "R3 length bin";
    if (k <= 20) return "R5 class";
    if (k == 25 || k == 26) return "R7 start/len-err";
    return "R6 pause/pfc/crc";
  endfunction

  task automatic read_all(input string tag);
    for (int i = 0; i < 56; i++) rd(i, tag == "" ? tag_of(i/2) : tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_val("R11 ev_ready", {31'd0, ev_ready}, 32'd1);
    read_all("R1 reset");
    rd(7'h40, "R1 status reset");
    rd(7'h41, "R1 cfg reset");

    // main patterns, back-to-back
    frame(40, 1, 0, 0, 0, 0, 0);
    frame(64, 0, 0, 0, 0, 0, 0);
    frame(100, 0, 1, 0, 0, 0, 0);
    frame(200, 1, 2, 0, 0, 0, 0);
    frame(300, 0, 0, 1, 0, 0, 0);
    frame(600, 0, 1, 1, 0, 0, 0);
    frame(1200, 1, 2, 1, 0, 0, 0);
    frame(1518, 0, 0, 0, 0, 0, 0);
    frame(1519, 0, 1, 0, 0, 0, 0);
    frame(1600, 0, 2, 0, 0, 0, 0);
    frame(1601, 1, 0, 0, 0, 0, 0);
    frame(64, 0, 1, 1, 1, 0, 0);
    frame(64, 1, 1, 1, 1, 0, 0);
    frame(64, 0, 0, 1, 0, 1, 0);
    frame(80, 1, 0, 1, 0, 1, 0);
    frame(70, 0, 3, 0, 0, 0, 1);
    check_val("R11 ev_ready busy", {31'd0, ev_ready}, 32'd1);
    repeat (3) begin sof_pulse = 1; step(); end
    read_all("");

    // snapshot rising together with a frame (R8)
    snap_in = 1; set_frame(64, 0, 0, 0, 0, 0, 0); step();
    frame(500, 0, 2, 0, 0, 0, 0);
    frame(30, 1, 1, 0, 0, 0, 0);
    rd(7'h40, "R8 status set");
    for (int i = 0; i < 56; i += 2) rd(i, "R8 frozen view");
    snap_in = 0; step();
    rd(7'h40, "R9 status clear");
    read_all("R9 live after release");

    // software freeze path (R8)
    wr(7'h41, 2);
    frame(2000, 0, 0, 0, 0, 0, 0);
    rd(7'h41, "R10 cfg bit1");
    rd(7'h40, "R8 soft status");
    for (int i = 0; i < 56; i += 2) rd(i, "R8 soft frozen");
    wr(7'h41, 0);
    step();
    read_all("R9 soft release");

    // clear and event in the same cycle (R10)
    set_frame(64, 0, 0, 0, 0, 0, 0); wr_addr = 7'h41; wr_data = 2'd1; wr_en = 1; step();
    read_all("R10 clear wins");

    // clear during a snapshot (R10)
    frame(128, 0, 1, 0, 0, 0, 0);
    snap_in = 1; step(); step();
    frame(256, 0, 1, 0, 0, 0, 0);
    wr(7'h41, 1);
    for (int i = 0; i < 56; i += 2) rd(i, "R10 shadow cleared");
    snap_in = 0; step();
    frame(1024, 1, 2, 1, 0, 0, 0);
    read_all("R10 after clear");

    repeat (4) step();
    check_val("R2 all reads returned", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule